// File: doc/BRIEF.md
# Mailbox FIFO Interrupt Aggregator

This block sits between a host-facing register window and a device-side agent. It holds eight byte-wide mailbox FIFOs. Mailboxes 0 to 3 carry bytes from the host to the device. Mailboxes 4 to 7 carry bytes from the device to the host. The host reaches everything through one byte-wide access port that has a function select (0 or 1) and a byte address. Reading a mailbox range pops a byte. Writing a mailbox range pushes a byte. The device side has its own push port into mailboxes 4 to 7 and its own pop port out of mailboxes 0 to 3.

Interrupt state is derived on two levels. The function-1 status combines the occupancy of the device-to-host mailboxes with three sticky sub-sources: counter, CPU and error. Each sub-source is gated by its own enable. The function-0 status folds the enabled function-1 status into a single bit. A master enable bit then gates the one interrupt line. All status is recomputed combinationally from current state, so it always matches FIFO occupancy with no lag.

The window has some extra features. It reports which device-to-host mailboxes hold at least a threshold number of bytes. It offers a four-byte look-ahead into mailbox 4 that does not pop. It also gives a one-cycle command-ready strobe when the host writes the last byte address of the mailbox-0 range.

Top module: `mbx_irq_window`

## Requirements
- R1: Function-1 status (f1 0x400) bits 3:0 are set exactly while mailboxes 7:4 are non-empty. Bit 5 reads zero.
- R2: Function-1 status bit 4 is set when the counter sub-status AND the counter enable is nonzero. Bit 6 does the same for CPU, and bit 7 for error.
- R3: Function-0 status (f0 0x05) bit 1 is set exactly when the function-1 status AND the function-1 enable is nonzero. All its other bits read zero.
- R4: `irqOut` is high exactly when function-0 enable bit 0 is set and the function-0 status AND the function-0 enable is nonzero.
- R5: Register map. f0 0x04 is the function-0 enable (read/write). f0 0x05 is the function-0 status. f1 0x400 is the status, and f1 0x401, 0x402 and 0x403 are the CPU, error and counter sub-statuses. f1 0x418, 0x419, 0x41A and 0x41B are the function-1, CPU, error and counter enables (read/write). Every unmapped read returns 0.
- R6: f1 0x405 bit n is set while mailbox 4+n holds at least 4 bytes. Bits 7:4 read zero.
- R7: f1 0x408+k (k = 0..3) returns byte k after the read pointer of mailbox 4 without popping it, or 0 when the mailbox holds k bytes or fewer.
- R8: Host reads at f1 0x000-0x3FF pop mailbox 4 + addr[9:8]. Host writes to that range push mailbox addr[9:8]. Device pushes go to mailbox 4 + `devPushBox`, device pops come from mailbox `devPopBox`, and every mailbox is first-in first-out.
- R9: Any host read or write at f1 0x440 clears counter sub-status bit 0. A simultaneous `cntSet[0]` pulse wins.
- R10: Each mailbox holds 512 bytes. A push to a full mailbox is dropped and sets that mailbox's bit in `ovfFlags` until reset. A pop from an empty mailbox returns 0 and changes nothing.
- R11: A host write to f1 0x0FF drives `cmdReady` high for the one following cycle. Writes to other addresses, or to function 0, do not.
- R12: The CPU, error and counter sub-statuses are sticky ORs of their `*Set` pulse inputs. Only reset clears the CPU and error sub-statuses.
- R13: After reset all FIFOs are empty, all enables and sub-statuses are zero, and `irqOut`, `cmdReady` and `ovfFlags` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostRd | input | 1 | Host read strobe (ignored while hostWr is high) |
| hostWr | input | 1 | Host write strobe |
| hostFunc | input | 1 | Function select: 0 or 1 |
| hostAddr | input | ADDR_W | Host byte address |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte, valid in the cycle of hostRd |
| devPush | input | 1 | Device push strobe |
| devPushBox | input | 2 | Target mailbox 4 + value |
| devPushData | input | 8 | Device push byte |
| devPop | input | 1 | Device pop strobe |
| devPopBox | input | 2 | Source mailbox 0 + value |
| devPopData | output | 8 | Head byte of the selected mailbox, 0 when empty |
| cntSet | input | 8 | Counter sub-status set pulses |
| cpuSet | input | 8 | CPU sub-status set pulses |
| errSet | input | 8 | Error sub-status set pulses |
| irqOut | output | 1 | Aggregated interrupt |
| cmdReady | output | 1 | Command-ready strobe |
| ovfFlags | output | 8 | Sticky per-mailbox overflow flags |

## Verification
The assertions assume that the host strobes a read or a write but not both in one cycle. They also assume the device-side pop selects only mailboxes 0 to 3 and the device-side push selects only mailboxes 4 to 7, which the two-bit selectors guarantee. The stimulus drives at most one host access per cycle and releases every strobe before the next access. Sub-status set pulses are applied one cycle at a time and never overlap a host access, except in the one case that tests the set-over-clear priority on purpose.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

  typedef enum logic [3:0] {
    RS_ZERO, RS_F0EN, RS_F0ST, RS_F1ST, RS_CPU, RS_ERR,
    RS_CNT, RS_LVL, RS_PEEK, RS_F1EN, RS_MBOX
  } rdSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic [3:0] hostPush;  // push mailboxes 0..3
    logic [3:0] hostPop;   // pop mailboxes 4..7
    logic       f0EnWr;
    logic [3:0] f1EnWr;    // main, cpu, err, cnt enables
    logic       clrCnt0;
    rdSel_e     rdSel;
    logic [1:0] idx;
  } ctrlStrb_t;

endpackage

// File: rtl/mbx_fifo.sv
`timescale 1ns/1ps
module mbx_fifo #(
  parameter int DEPTH = 512,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  input  logic [1:0]    rdIdx,
  output logic [W-1:0]  rdByte,
  output logic [CW-1:0] count,
  output logic          ovf
);
  localparam logic [CW-1:0] DEPTH_V = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_P  = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr, rdAddr;
  logic [CW-1:0] sum;
  logic          empty, full, doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == DEPTH_V);
  assign doPop  = pop && !empty;
  assign doPush = push && (!full || doPop);

  // look-ahead address with wrap
  always_comb begin
    sum = {1'b0, rdPtr} + CW'(rdIdx);
    if (sum >= DEPTH_V) rdAddr = PW'(sum - DEPTH_V);
    else                rdAddr = PW'(sum);
  end
  assign rdByte = mem[rdAddr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_P) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_P) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && !doPush) ovf <= 1'b1;
    end
  end

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_V);
  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push) |=> (count == '0));
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> ovf);
  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (full && ovf));

endmodule

// File: rtl/mbx_ctrl.sv
`timescale 1ns/1ps
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic              hostFunc,
  input  logic [ADDR_W-1:0] hostAddr,
  output ctrlStrb_t         strb,
  output logic              cmdReady
);
  localparam logic [15:0] CMD_ADDR = 16'h00FF;

  logic [15:0] a;
  logic        rd, wr;

  assign a  = 16'(hostAddr);
  assign wr = hostWr;
  assign rd = hostRd && !hostWr;

  always_comb begin
    strb       = '0;
    strb.rdSel = RS_ZERO;
    strb.idx   = a[1:0];
    if (!hostFunc) begin
      if (a == 16'h0004) begin
        strb.rdSel  = RS_F0EN;
        strb.f0EnWr = wr;
      end else if (a == 16'h0005) begin
        strb.rdSel = RS_F0ST;
      end
    end else if (a < 16'h0400) begin
      strb.idx   = a[9:8];
      strb.rdSel = RS_MBOX;
      strb.hostPop[a[9:8]]  = rd;
      strb.hostPush[a[9:8]] = wr;
    end else if (a[15:8] == 8'h04) begin
      case (a[7:0])
        8'h00: strb.rdSel = RS_F1ST;
        8'h01: strb.rdSel = RS_CPU;
        8'h02: strb.rdSel = RS_ERR;
        8'h03: strb.rdSel = RS_CNT;
        8'h05: strb.rdSel = RS_LVL;
        8'h08, 8'h09, 8'h0A, 8'h0B: strb.rdSel = RS_PEEK;
        8'h18, 8'h19, 8'h1A, 8'h1B: begin
          strb.rdSel = RS_F1EN;
          strb.f1EnWr[a[1:0]] = wr;
        end
        8'h40: strb.clrCnt0 = rd || wr;
        default: strb.rdSel = RS_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cmdReady <= 1'b0;
    else       cmdReady <= wr && hostFunc && (a == CMD_ADDR);
  end

  // R11
  cmd_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> ($past(hostWr) && $past(hostFunc)));
  // R8
  one_mbox_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.hostPush, strb.hostPop}));

endmodule

// File: rtl/mbx_datapath.sv
`timescale 1ns/1ps
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int DEPTH   = 512,
  parameter int LVL_THR = 4,
  localparam int CW     = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrb_t  strb,
  input  logic [7:0] hostWrData,
  input  logic       devPush,
  input  logic [1:0] devPushBox,
  input  logic [7:0] devPushData,
  input  logic       devPop,
  input  logic [1:0] devPopBox,
  output logic [7:0] devPopData,
  input  logic [7:0] cntSet,
  input  logic [7:0] cpuSet,
  input  logic [7:0] errSet,
  output logic [7:0] hostRdData,
  output logic       irqOut,
  output logic [7:0] ovfFlags
);
  localparam logic [CW-1:0] THR_V = CW'(LVL_THR);

  logic [7:0]    boxByte [8];
  logic [CW-1:0] boxCnt  [8];
  logic [3:0]    nonEmpty, lvlHit;
  logic [7:0]    f0En, f1En, cpuEn, errEn, cntEn;
  logic [7:0]    cpuStat, errStat, cntStat;
  logic [7:0]    f1Stat, f0Stat, peekByte, mboxByte, f1EnRd;
  logic [2:0]    popSel, hostSel;

  // host-to-device mailboxes 0..3
  for (genvar b = 0; b < 4; b++) begin : g_h2d
    mbx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
      .clk(clk), .rstN(rstN),
      .push(strb.hostPush[b]), .pushData(hostWrData),
      .pop(devPop && (devPopBox == 2'(b))), .rdIdx(2'd0),
      .rdByte(boxByte[b]), .count(boxCnt[b]), .ovf(ovfFlags[b]));
  end

  // device-to-host mailboxes 4..7; mailbox 4 carries the look-ahead
  for (genvar b = 4; b < 8; b++) begin : g_d2h
    logic [1:0] idxSel;
    if (b == 4) begin : g_peek
      assign idxSel = (strb.rdSel == RS_PEEK) ? strb.idx : 2'd0;
    end else begin : g_nopeek
      assign idxSel = 2'd0;
    end
    mbx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
      .clk(clk), .rstN(rstN),
      .push(devPush && (devPushBox == 2'(b - 4))), .pushData(devPushData),
      .pop(strb.hostPop[b-4]), .rdIdx(idxSel),
      .rdByte(boxByte[b]), .count(boxCnt[b]), .ovf(ovfFlags[b]));
    assign nonEmpty[b-4] = (boxCnt[b] != '0);
    assign lvlHit[b-4]   = (boxCnt[b] >= THR_V);
  end

  assign popSel     = {1'b0, devPopBox};
  assign devPopData = (boxCnt[popSel] != '0) ? boxByte[popSel] : 8'h00;

  // enables and sticky sub-statuses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      f0En <= '0; f1En <= '0; cpuEn <= '0; errEn <= '0; cntEn <= '0;
      cpuStat <= '0; errStat <= '0; cntStat <= '0;
    end else begin
      if (strb.f0EnWr)    f0En  <= hostWrData;
      if (strb.f1EnWr[0]) f1En  <= hostWrData;
      if (strb.f1EnWr[1]) cpuEn <= hostWrData;
      if (strb.f1EnWr[2]) errEn <= hostWrData;
      if (strb.f1EnWr[3]) cntEn <= hostWrData;
      cpuStat <= cpuStat | cpuSet;
      errStat <= errStat | errSet;
      cntStat <= (cntStat & ~{7'd0, strb.clrCnt0}) | cntSet;
    end
  end

  // two-level status, recomputed every cycle
  always_comb begin
    f1Stat = {|(errStat & errEn), |(cpuStat & cpuEn), 1'b0,
              |(cntStat & cntEn), nonEmpty};
    f0Stat = {6'd0, |(f1Stat & f1En), 1'b0};
    irqOut = f0En[0] && |(f0Stat & f0En);
  end

  assign peekByte = (boxCnt[4] > CW'(strb.idx)) ? boxByte[4] : 8'h00;
  assign hostSel  = {1'b1, strb.idx};
  assign mboxByte = (boxCnt[hostSel] != '0) ? boxByte[hostSel] : 8'h00;

  always_comb begin
    case (strb.idx)
      2'd0:    f1EnRd = f1En;
      2'd1:    f1EnRd = cpuEn;
      2'd2:    f1EnRd = errEn;
      default: f1EnRd = cntEn;
    endcase
  end

  always_comb begin
    case (strb.rdSel)
      RS_F0EN: hostRdData = f0En;
      RS_F0ST: hostRdData = f0Stat;
      RS_F1ST: hostRdData = f1Stat;
      RS_CPU:  hostRdData = cpuStat;
      RS_ERR:  hostRdData = errStat;
      RS_CNT:  hostRdData = cntStat;
      RS_LVL:  hostRdData = {4'd0, lvlHit};
      RS_PEEK: hostRdData = peekByte;
      RS_F1EN: hostRdData = f1EnRd;
      RS_MBOX: hostRdData = mboxByte;
      default: hostRdData = 8'h00;
    endcase
  end

  // R4
  irq_master_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> f0En[0]);
  // R5
  f0en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.f0EnWr |=> $stable(f0En));
  // R9
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrCnt0 && !cntSet[0]) |=> !cntStat[0]);
  // R12
  cpu_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((cpuStat & $past(cpuStat)) == $past(cpuStat)));
  // R12
  err_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((errStat & $past(errStat)) == $past(errStat)));

endmodule

// File: rtl/mbx_irq_window.sv
`timescale 1ns/1ps
module mbx_irq_window
  import mbx_pkg::*;
#(
  parameter int DEPTH   = 512,
  parameter int LVL_THR = 4,
  parameter int ADDR_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic              hostFunc,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWrData,
  output logic [7:0]        hostRdData,
  input  logic              devPush,
  input  logic [1:0]        devPushBox,
  input  logic [7:0]        devPushData,
  input  logic              devPop,
  input  logic [1:0]        devPopBox,
  output logic [7:0]        devPopData,
  input  logic [7:0]        cntSet,
  input  logic [7:0]        cpuSet,
  input  logic [7:0]        errSet,
  output logic              irqOut,
  output logic              cmdReady,
  output logic [7:0]        ovfFlags
);
  ctrlStrb_t strb;

  mbx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr),
    .hostFunc(hostFunc), .hostAddr(hostAddr), .strb(strb),
    .cmdReady(cmdReady));

  mbx_datapath #(.DEPTH(DEPTH), .LVL_THR(LVL_THR)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWrData(hostWrData),
    .devPush(devPush), .devPushBox(devPushBox), .devPushData(devPushData),
    .devPop(devPop), .devPopBox(devPopBox), .devPopData(devPopData),
    .cntSet(cntSet), .cpuSet(cpuSet), .errSet(errSet),
    .hostRdData(hostRdData), .irqOut(irqOut), .ovfFlags(ovfFlags));

  // R13
  irq_low_reset_chk: assert property (@(posedge clk)
    !rstN |=> !irqOut);

endmodule

// File: tb/mbx_irq_window_test.sv
`timescale 1ns/1ps
module mbx_irq_window_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostRd = 1'b0, hostWr = 1'b0, hostFunc = 1'b0;
  logic [10:0] hostAddr = '0;
  logic [7:0]  hostWrData = '0, hostRdData;
  logic        devPush = 1'b0, devPop = 1'b0;
  logic [1:0]  devPushBox = '0, devPopBox = '0;
  logic [7:0]  devPushData = '0, devPopData;
  logic [7:0]  cntSet = '0, cpuSet = '0, errSet = '0;
  logic        irqOut, cmdReady;
  logic [7:0]  ovfFlags;

  int total = 0;
  int bad   = 0;

  mbx_irq_window uut (
    .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr),
    .hostFunc(hostFunc), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .devPush(devPush), .devPushBox(devPushBox),
    .devPushData(devPushData), .devPop(devPop), .devPopBox(devPopBox),
    .devPopData(devPopData), .cntSet(cntSet), .cpuSet(cpuSet),
    .errSet(errSet), .irqOut(irqOut), .cmdReady(cmdReady),
    .ovfFlags(ovfFlags));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic hwr(input logic f, input int a, input int d);
    @(negedge clk);
    hostWr = 1'b1; hostFunc = f; hostAddr = 11'(a); hostWrData = 8'(d);
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hrd(input logic f, input int a, output int d);
    @(negedge clk);
    hostRd = 1'b1; hostFunc = f; hostAddr = 11'(a);
    #1 d = int'(hostRdData);
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic dpush(input int box, input int d);
    @(negedge clk);
    devPush = 1'b1; devPushBox = 2'(box); devPushData = 8'(d);
    @(negedge clk);
    devPush = 1'b0;
  endtask

  task automatic dpop(input int box, output int d);
    @(negedge clk);
    devPop = 1'b1; devPopBox = 2'(box);
    #1 d = int'(devPopData);
    @(negedge clk);
    devPop = 1'b0;
  endtask

  task automatic subset(input int c, input int p, input int e);
    @(negedge clk);
    cntSet = 8'(c); cpuSet = 8'(p); errSet = 8'(e);
    @(negedge clk);
    cntSet = '0; cpuSet = '0; errSet = '0;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d, p, q, exp, f1e, f1st, f0st, expIrq;
    int f1List[6];
    f1List = '{0, 8'h10, 8'h40, 8'h80, 8'hFF, 8'h0F};
    doReset();

    // R13 reset state
    #1;
    chk("R13 irq", irqOut, 0);
    chk("R13 cmdReady", cmdReady, 0);
    chk("R13 ovf", ovfFlags, 0);
    hrd(0, 5, d); chk("R13 f0 status", d, 0);
    hrd(1, 'h400, d); chk("R13 f1 status", d, 0);
    hrd(1, 'h41B, d); chk("R13 cnt enable", d, 0);

    // R5 register map
    hwr(0, 4, 'hA4); hrd(0, 4, d); chk("R5 f0 enable", d, 'hA4);
    for (int i = 0; i < 4; i++) hwr(1, 'h418 + i, 'h31 + i * 16);
    for (int i = 0; i < 4; i++) begin
      hrd(1, 'h418 + i, d); chk("R5 f1 enables", d, 'h31 + i * 16);
    end
    hrd(0, 'h10, d); chk("R5 unmapped f0", d, 0);
    hrd(1, 'h404, d); chk("R5 unmapped f1", d, 0);
    hrd(1, 'h41C, d); chk("R5 unmapped f1 hi", d, 0);

    // R1 / R8 occupancy sweep over all 16 patterns
    doReset();
    for (int pt = 0; pt < 16; pt++) begin
      for (int i = 0; i < 4; i++)
        if (pt[i]) dpush(i, pt * 16 + i);
      hrd(1, 'h400, d); chk("R1 status occupancy", d, pt);
      chk("R4 irq off while disabled", irqOut, 0);
      for (int i = 0; i < 4; i++)
        if (pt[i]) begin
          hrd(1, i * 256 + 'h37, d); chk("R8 pop mailbox", d, pt * 16 + i);
        end
      hrd(1, 'h400, d); chk("R1 drained", d, 0);
    end

    // R2 / R3 / R4 enable sweep
    doReset();
    subset('h02, 'h04, 'h08);
    for (int e = 0; e < 8; e++) begin
      hwr(1, 'h419, e[0] ? 'h04 : 'hFB);
      hwr(1, 'h41A, e[1] ? 'h08 : 'hF7);
      hwr(1, 'h41B, e[2] ? 'h02 : 'hFD);
      f1st = (e[0] ? 'h40 : 0) | (e[1] ? 'h80 : 0) | (e[2] ? 'h10 : 0);
      hrd(1, 'h400, d); chk("R2 masked sub-status", d, f1st);
      for (int k = 0; k < 6; k++) begin
        f1e = f1List[k];
        hwr(1, 'h418, f1e);
        f0st = ((f1st & f1e) != 0) ? 2 : 0;
        for (int f0e = 0; f0e < 4; f0e++) begin
          hwr(0, 4, f0e);
          hrd(0, 5, d); chk("R3 f0 status", d, f0st);
          expIrq = ((f0e & 1) != 0 && (f0st & f0e) != 0) ? 1 : 0;
          chk("R4 irq", irqOut, expIrq);
        end
      end
    end

    // R4 via mailbox occupancy
    doReset();
    hwr(1, 'h418, 'h08); hwr(0, 4, 3);
    #1 chk("R4 irq idle", irqOut, 0);
    dpush(3, 'h5A);
    chk("R4 irq from mailbox 7", irqOut, 1);
    hrd(1, 'h3C0, d); chk("R8 mailbox 7 data", d, 'h5A);
    chk("R4 irq after pop", irqOut, 0);

    // R9 / R12 sub-status behaviour
    doReset();
    subset('h03, 'h00, 'h00);
    hrd(1, 'h403, d); chk("R12 counter set", d, 3);
    hrd(1, 'h440, d); chk("R9 clear read returns 0", d, 0);
    hrd(1, 'h403, d); chk("R9 clear by read", d, 2);
    subset('h01, 0, 0);
    hwr(1, 'h440, 'hFF);
    hrd(1, 'h403, d); chk("R9 clear by write", d, 2);
    @(negedge clk);
    cntSet = 8'h01; hostWr = 1'b1; hostFunc = 1'b1; hostAddr = 11'h440;
    @(negedge clk);
    cntSet = '0; hostWr = 1'b0;
    hrd(1, 'h403, d); chk("R9 set wins", d, 3);
    subset(0, 'h21, 'h80);
    subset(0, 'h02, 'h01);
    repeat (10) @(negedge clk);
    hrd(1, 'h401, d); chk("R12 cpu sticky", d, 'h23);
    hrd(1, 'h402, d); chk("R12 err sticky", d, 'h81);
    hwr(1, 'h440, 0);
    hrd(1, 'h401, d); chk("R12 cpu unaffected by clear", d, 'h23);

    // R6 / R7 level flags and look-ahead
    doReset();
    dpush(0, 'h11); dpush(0, 'h22); dpush(0, 'h33);
    hrd(1, 'h405, d); chk("R6 below threshold", d, 0);
    hrd(1, 'h408, d); chk("R7 peek 0", d, 'h11);
    hrd(1, 'h409, d); chk("R7 peek 1", d, 'h22);
    hrd(1, 'h40A, d); chk("R7 peek 2", d, 'h33);
    hrd(1, 'h40B, d); chk("R7 peek beyond", d, 0);
    dpush(0, 'h44);
    hrd(1, 'h405, d); chk("R6 threshold box4", d, 1);
    hrd(1, 'h40B, d); chk("R7 peek 3", d, 'h44);
    for (int i = 0; i < 4; i++) dpush(2, i);
    hrd(1, 'h405, d); chk("R6 threshold box4+6", d, 5);
    hrd(1, 'h000, d); chk("R7 peek did not pop", d, 'h11);
    hrd(1, 'h408, d); chk("R7 peek after pop", d, 'h22);
    hrd(1, 'h405, d); chk("R6 box4 dropped below", d, 4);

    // R8 host push order, R11 command strobe
    doReset();
    hwr(1, 'h100, 'hA1); hwr(1, 'h1FE, 'hA2); hwr(1, 'h2A5, 'hB1);
    dpop(1, d); chk("R8 mbox1 first", d, 'hA1);
    dpop(1, d); chk("R8 mbox1 second", d, 'hA2);
    dpop(2, d); chk("R8 mbox2", d, 'hB1);
    hwr(1, 'h0FE, 1); chk("R11 no strobe other addr", cmdReady, 0);
    hwr(0, 'h0FF, 1); chk("R11 no strobe func0", cmdReady, 0);
    hwr(1, 'h0FF, 2); chk("R11 strobe", cmdReady, 1);
    @(negedge clk); chk("R11 strobe one cycle", cmdReady, 0);

    // R10 capacity, overflow, empty pop
    doReset();
    for (int i = 0; i < 512; i++) hwr(1, 'h010, i);
    chk("R10 no overflow at 512", ovfFlags, 0);
    hwr(1, 'h010, 'hEE);
    chk("R10 overflow flag", ovfFlags, 1);
    exp = 0;
    for (int i = 0; i < 512; i++) begin
      dpop(0, d);
      if (d != (i & 255)) exp++;
    end
    chk("R10 512 bytes in order", exp, 0);
    dpop(0, d); chk("R10 empty pop zero", d, 0);
    hwr(1, 'h020, 'h77);
    dpop(0, d); chk("R10 no change after empty pop", d, 'h77);
    chk("R10 overflow sticky", ovfFlags, 1);
    hrd(1, 'h140, d); chk("R10 empty host pop zero", d, 0);
    dpush(1, 'h66);
    hrd(1, 'h140, d); chk("R10 box5 after empty pop", d, 'h66);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule